// File: doc/BRIEF.md
# Shift-Register FIFO with Occupancy Counter

A single-clock, 16-word synchronous FIFO built without a dual-port memory. Every bit of the data word has its own 16-stage shift register with a selectable output tap. An accepted write pushes the new word into stage 0, and every stored word moves one stage deeper. A single up/down counter tracks how many words are held. That same counter value, minus one, selects the tap where the oldest word sits.

The read port is first-word fall-through. While the FIFO is not empty, `rd_data_o` already shows the oldest word, and an accepted read strobe removes that word at the next clock edge. The occupancy count comes out as a port, together with empty, full and half-full flags decoded from it. The data width is a parameter. The depth is fixed at 16.

Top module: `shift_fifo`

## Requirements
- R1: While `rst_ni` is low, the count is cleared to 0 without a clock edge. After reset, `empty_o`=1, `full_o`=0, `half_o`=0 and `count_o`=0. Stored words are not cleared.
- R2: An accepted write with no accepted read raises `count_o` by one at the clock edge. An accepted read with no accepted write lowers it by one.
- R3: When a read and a write are both accepted in the same cycle, `count_o` is unchanged. The oldest word leaves, and the new word joins at the tail.
- R4: While `count_o` > 0, `rd_data_o` equals the oldest stored word. Words leave in exactly the order they were accepted. With no accepted strobe, `rd_data_o` holds its value.
- R5: `empty_o` is 1 exactly when `count_o` is 0.
- R6: `full_o` is 1 exactly when `count_o` is 16.
- R7: `half_o` is 1 exactly when `count_o` is 8 or more.
- R8: `wr_i` is ignored while `full_o` is 1: the count and the contents are unaffected. A read in the same cycle is still accepted, which leaves 15 words.
- R9: `rd_i` is ignored while `empty_o` is 1: the count stays 0. A write in the same cycle is still accepted, which leaves 1 word.
- R10: `count_o` (5 bits) always equals the number of words held, in the range 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, empties the FIFO |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Word to write |
| rd_i | input | 1 | Read strobe, removes the word on `rd_data_o` |
| rd_data_o | output | DATA_W | Oldest stored word (valid while not empty) |
| full_o | output | 1 | 16 words held |
| empty_o | output | 1 | No words held |
| half_o | output | 1 | 8 or more words held |
| count_o | output | 5 | Number of words held |

## Verification
The occupancy counter is also the read address. A counter that is off by one therefore shows up at the ports in two ways in the very next cycle: `count_o` and the flags are wrong, and `rd_data_o` shows the neighbouring word instead of the oldest one. A fault in the shift path of a single bit corrupts only that bit of a word, and it appears when that word reaches the head of the queue. The sweeps compare every output after every edge against an arithmetic queue model. Such faults are therefore reported in the cycle they become visible.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W  = ADDR_W + 1;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] tap_t;

  // net effect of one cycle on the occupancy
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } op_e;
endpackage

// File: rtl/sf_tap_sreg.sv
// one data bit: shift register with a selectable output tap
module sf_tap_sreg #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          shift_i,
  input  logic          d_i,
  input  logic [AW-1:0] tap_i,
  output logic          q_o
);
  logic [DEPTH-1:0] stage_q;

  // storage has no reset on purpose
  always_ff @(posedge clk_i) begin
    if (shift_i) stage_q <= {stage_q[DEPTH-2:0], d_i};
  end

  assign q_o = stage_q[tap_i];
endmodule

// File: rtl/sf_occ_ctr.sv
module sf_occ_ctr
  import shift_fifo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  output cnt_t cnt_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        OP_PUSH: cnt_q <= cnt_q + cnt_t'(1);
        OP_POP:  cnt_q <= cnt_q - cnt_t'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cnt_t'(DEPTH)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH) |-> (cnt_q != cnt_t'(DEPTH))); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP) |-> (cnt_q != '0)); // R9
endmodule

// File: rtl/sf_flags.sv
module sf_flags
  import shift_fifo_pkg::*;
(
  input  cnt_t cnt_i,
  output logic empty_o,
  output logic full_o,
  output logic half_o,
  output tap_t tap_o
);
  cnt_t last;

  assign empty_o = (cnt_i == '0);
  assign full_o  = cnt_i[CNT_W-1];
  // 8..15 set bit 3, 16 sets bit 4
  assign half_o  = cnt_i[CNT_W-1] | cnt_i[CNT_W-2];
  // oldest word sits at stage count-1
  assign last    = cnt_i - cnt_t'(1);
  assign tap_o   = last[ADDR_W-1:0];
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import shift_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              half_o,
  output logic [CNT_W-1:0]  count_o
);
  logic wr_ok, rd_ok;
  op_e  op;
  cnt_t cnt;
  tap_t tap;

  assign wr_ok = wr_i & ~full_o;
  assign rd_ok = rd_i & ~empty_o;
  assign op    = op_e'({rd_ok, wr_ok});

  sf_occ_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .cnt_o  (cnt)
  );

  sf_flags u_flags (
    .cnt_i   (cnt),
    .empty_o (empty_o),
    .full_o  (full_o),
    .half_o  (half_o),
    .tap_o   (tap)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    sf_tap_sreg #(.DEPTH(DEPTH)) u_sreg (
      .clk_i   (clk_i),
      .shift_i (wr_ok),
      .d_i     (wr_data_i[b]),
      .tap_i   (tap),
      .q_o     (rd_data_o[b])
    );
  end

  assign count_o = cnt;

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !rd_i |=> full_o && $stable(rd_data_o)); // R8
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_i && !wr_i |=> empty_o); // R9
  AST_SWAP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && rd_i && !empty_o && !full_o |=> $stable(count_o)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !rd_i && !empty_o |=> $stable(count_o) && $stable(rd_data_o)); // R4
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !rd_i && !full_o |=> count_o == $past(count_o) + 1'b1); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o)); // R5
  AST_HALF_BELOW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o); // R7
endmodule

// File: tb/sim_shift_fifo.sv
`timescale 1ns/1ps
module sim_shift_fifo;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdat = '0;
  logic [DW-1:0] rdat;
  logic full, empty, half;
  logic [4:0] cnt;

  int n_chk = 0, n_bad = 0;
  int mcnt = 0;
  int mq [16];
  int seed = 32'h1ACE;

  always #2 clk = ~clk;

  shift_fifo #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdat), .rd_i(rd),
    .rd_data_o(rdat), .full_o(full), .empty_o(empty), .half_o(half), .count_o(cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk("R10", {tag, " count"}, int'(cnt), mcnt);
    chk("R5", {tag, " empty"}, int'(empty), int'(mcnt == 0));
    chk("R6", {tag, " full"}, int'(full), int'(mcnt == 16));
    chk("R7", {tag, " half"}, int'(half), int'(mcnt >= 8));
    if (mcnt > 0) chk("R4", {tag, " head"}, int'(rdat), mq[0]);
  endtask

  // one cycle: drive, clock, update model, check
  task automatic cyc(input logic w, input int d, input logic r, input string tag);
    bit wok, rok;
    wr = w; rd = r; wdat = DW'(d);
    wok = w && (mcnt < 16);
    rok = r && (mcnt > 0);
    @(posedge clk); #1;
    if (rok) begin
      for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (wok) begin
      mq[mcnt] = d & 8'hFF;
      mcnt++;
    end
    wr = 1'b0; rd = 1'b0;
    check_all(tag);
  endtask

  function automatic int nxt(inout int s);
    s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
    return s;
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #9 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1", "reset count", int'(cnt), 0);
    chk("R1", "reset empty", int'(empty), 1);
    chk("R1", "reset full", int'(full), 0);
    chk("R1", "reset half", int'(half), 0);

    // R9 read while empty ignored
    cyc(1'b0, 0, 1'b1, "R9 rd empty");
    cyc(1'b1, 8'h5A, 1'b1, "R9 rd+wr empty");
    cyc(1'b0, 0, 1'b1, "R2 pop");

    // R2 fill past full, R8 extra writes ignored
    for (int i = 0; i < 18; i++) cyc(1'b1, i * 37 + 5, 1'b0, "R2 R8 fill");
    cyc(1'b1, 8'hEE, 1'b1, "R8 rd+wr full");
    cyc(1'b1, 8'h11, 1'b0, "R2 refill");
    for (int i = 0; i < 17; i++) cyc(1'b0, 0, 1'b1, "R4 drain");

    // R3 swaps at every fill level
    for (int k = 0; k <= 16; k++) begin
      for (int i = 0; i < k; i++) cyc(1'b1, k * 16 + i, 1'b0, "R2 level");
      for (int j = 0; j < 4; j++) cyc(1'b1, 200 + k + j, 1'b1, "R3 swap");
      for (int j = 0; j < 2; j++) cyc(1'b0, 0, 1'b0, "R4 idle");
      while (mcnt > 0) cyc(1'b0, 0, 1'b1, "R4 order");
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int v;
      v = nxt(seed);
      cyc(v[0] | v[3], v[15:8], v[1] & ~v[5], "R4 mix");
    end

    // R1 mid-run reset empties
    while (mcnt < 10) cyc(1'b1, mcnt, 1'b0, "R2 pre-reset");
    #1 rst_n = 1'b0;
    #1;
    mcnt = 0;
    chk("R1", "async count", int'(cnt), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after reset");
    cyc(1'b1, 8'hC3, 1'b0, "R1 R2 post-reset write");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule